// File: doc/BRIEF.md
# Two-Stage Pipeline Hazard Controller

This block holds the program counter and the pipeline register between the two stages of a small in-order processor. Stage 1 fetches, decodes, reads registers, runs the ALU and steps the PC. Stage 2 performs the data-memory access and writes the register file. The datapath sits outside the block. It supplies the decoded fields of the stage-1 instruction and a redirect request with its target. The block returns the PC, the stall and flush controls and the stage-2 control fields.

A read-after-write dependence exists when the stage-2 instruction writes a register that the stage-1 instruction reads. On such a dependence the controller freezes stage 1 for one cycle and sends a bubble down the pipe. A redirect comes from a taken branch or jump that is resolved for the instruction in stage 2. On a redirect the controller loads the target into the PC and kills the wrong-path instruction sitting in stage 1. The branch or jump itself always completes. Every killed or bubble slot becomes a canonical NOP, and all of its side-effect enables are cleared.

Top module: `hzd2_ctrl`

## Requirements
- R1: An active-low asynchronous reset takes effect without waiting for a clock edge. It sets `pc` to `RESET_PC` (0) and `s2_insn` to 32'h0000000F. It clears `s2_wr_en`, `s2_mem_wr`, `s2_branch` and `s2_jump`, and sets `s2_rd` to 0.
- R2: `stall` is 1 exactly when `s2_wr_en` is 1, `s2_rd` equals `s1_src[4:0]` or `s1_src[9:5]`, and `redirect` is 0. In every other case `stall` is 0, for example when stage 2 writes a register that stage 1 does not read, or when stage 2 writes no register.
- R3: In a stall cycle, `pc` keeps its value across the clock edge.
- R4: Each stall cycle puts exactly one bubble into stage 2. The stalled stage-1 instruction is kept, and it moves into stage 2 on the first cycle without a stall.
- R5: When `redirect` is 1, `flush` is 1, `pc` loads `redirect_pc`, and the stage-1 instruction is replaced in stage 2 by a NOP. The stage-2 instruction that requested the redirect is not affected.
- R6: With neither a stall nor a redirect, `flush` is 0 and `pc` advances by `PC_STEP` (4). A not-taken branch therefore causes no flush.
- R7: When a dependence and a redirect occur in the same cycle, the redirect wins. `stall` is 0, `flush` is 1 and `pc` loads the target.
- R8: A bubble or flushed slot holds `s2_insn` = 32'h0000000F and has `s2_wr_en`, `s2_mem_wr`, `s2_branch` and `s2_jump` all at 0.
- R9: When stage 1 is neither stalled nor flushed, stage 2 takes `s1_insn`, `s1_rd` and the four stage-1 enables on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s1_insn | input | INSN_W | Instruction word fetched at `pc` |
| s1_src | input | NUM_SRC*RIDX_W | Source register numbers of the stage-1 instruction; source k is at bits [k*RIDX_W +: RIDX_W] |
| s1_wr_en | input | 1 | Stage-1 instruction writes a register |
| s1_rd | input | RIDX_W | Destination register of the stage-1 instruction |
| s1_mem_wr | input | 1 | Stage-1 instruction writes memory |
| s1_branch | input | 1 | Stage-1 instruction is a conditional branch |
| s1_jump | input | 1 | Stage-1 instruction is a jump |
| redirect | input | 1 | Taken control transfer for the stage-2 instruction |
| redirect_pc | input | XLEN | Target address of the redirect |
| pc | output | XLEN | Fetch address |
| stall | output | 1 | Stage 1 is frozen this cycle |
| flush | output | 1 | Stage-1 instruction is killed this cycle |
| s2_insn | output | INSN_W | Stage-2 instruction word |
| s2_wr_en | output | 1 | Stage-2 register write enable |
| s2_rd | output | RIDX_W | Stage-2 destination register |
| s2_mem_wr | output | 1 | Stage-2 memory write enable |
| s2_branch | output | 1 | Stage-2 branch flag |
| s2_jump | output | 1 | Stage-2 jump flag |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and words, 5-bit register numbers, two source operands and a PC step of 4. With these values one program can reach every interesting case. It contains dependences through the first source and through the second, a load followed by a use, a store, and both a not-taken and a taken branch. It also contains a linking jump whose written register is read by the wrong-path instruction behind it, which produces a stall and a redirect in the same cycle. A reference model of the requirements predicts the PC trace, the stall pattern and each stage-2 slot. At the end the bench compares the total number of stalls from the block with the number the model predicts.

// File: rtl/hzd2_pkg.sv
package hzd2_pkg;

   // side-effect enables carried by a pipeline slot
   typedef struct packed {
      logic wr;   // register write
      logic mw;   // memory write
      logic br;   // branch
      logic jp;   // jump
   } fx_t;

   localparam logic [31:0] CANON_NOP = 32'h0000_000F;

   function automatic fx_t fx_none();
      fx_none = '0;
   endfunction

endpackage

// File: rtl/hzd2_dep_detect.sv
module hzd2_dep_detect #(
   parameter int RIDX_W  = 5,
   parameter int NUM_SRC = 2
) (
   input  logic [NUM_SRC*RIDX_W-1:0] src,
   input  logic                      wr_en,
   input  logic [RIDX_W-1:0]         rd,
   output logic                      hit
);
   logic [NUM_SRC-1:0] match;

   genvar g;
   generate
      for (g = 0; g < NUM_SRC; g++) begin : g_src
         assign match[g] = (src[g*RIDX_W +: RIDX_W] == rd);
      end
   endgenerate

   assign hit = wr_en & (|match);
endmodule

// File: rtl/hzd2_pc_reg.sv
module hzd2_pc_reg #(
   parameter int          XLEN     = 32,
   parameter int          PC_STEP  = 4,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold,
   input  logic            load,
   input  logic [XLEN-1:0] load_pc,
   output logic [XLEN-1:0] pc
);
   localparam logic [XLEN-1:0] STEP_V  = XLEN'(PC_STEP);
   localparam logic [XLEN-1:0] RESET_V = XLEN'(RESET_PC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pc <= RESET_V;
      else if (load) pc <= load_pc;
      else if (!hold) pc <= pc + STEP_V;
   end

   // R3
   pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !load) |=> $stable(pc));
   // R5
   pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (pc == $past(load_pc)));
   // R6
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !load) |=> (pc == $past(pc) + STEP_V));
endmodule

// File: rtl/hzd2_s2_reg.sv
module hzd2_s2_reg
   import hzd2_pkg::*;
#(
   parameter int          INSN_W   = 32,
   parameter int          RIDX_W   = 5,
   parameter logic [31:0] NOP_WORD = CANON_NOP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kill,
   input  logic [INSN_W-1:0] in_insn,
   input  logic [RIDX_W-1:0] in_rd,
   input  fx_t               in_fx,
   output logic [INSN_W-1:0] out_insn,
   output logic [RIDX_W-1:0] out_rd,
   output fx_t               out_fx
);
   localparam logic [INSN_W-1:0] NOP_V = INSN_W'(NOP_WORD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_insn <= NOP_V;
         out_rd   <= '0;
         out_fx   <= fx_none();
      end else if (kill) begin
         out_insn <= NOP_V;
         out_rd   <= '0;
         out_fx   <= fx_none();
      end else begin
         out_insn <= in_insn;
         out_rd   <= in_rd;
         out_fx   <= in_fx;
      end
   end

   // R8
   nop_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (out_insn == NOP_V && out_fx == 4'b0000));
   // R9
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !kill |=> (out_insn == $past(in_insn) && out_rd == $past(in_rd)));
endmodule

// File: rtl/hzd2_ctrl.sv
module hzd2_ctrl
   import hzd2_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          INSN_W   = 32,
   parameter int          RIDX_W   = 5,
   parameter int          NUM_SRC  = 2,
   parameter int          PC_STEP  = 4,
   parameter logic [31:0] RESET_PC = 32'h0,
   parameter logic [31:0] NOP_WORD = CANON_NOP
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [INSN_W-1:0]         s1_insn,
   input  logic [NUM_SRC*RIDX_W-1:0] s1_src,
   input  logic                      s1_wr_en,
   input  logic [RIDX_W-1:0]         s1_rd,
   input  logic                      s1_mem_wr,
   input  logic                      s1_branch,
   input  logic                      s1_jump,
   input  logic                      redirect,
   input  logic [XLEN-1:0]           redirect_pc,
   output logic [XLEN-1:0]           pc,
   output logic                      stall,
   output logic                      flush,
   output logic [INSN_W-1:0]         s2_insn,
   output logic                      s2_wr_en,
   output logic [RIDX_W-1:0]         s2_rd,
   output logic                      s2_mem_wr,
   output logic                      s2_branch,
   output logic                      s2_jump
);
   generate
      if (XLEN < 2 || INSN_W < 8 || RIDX_W < 1 || NUM_SRC < 1 || PC_STEP < 1) begin : g_bad
         $error("hzd2_ctrl: parameter out of range");
      end
   endgenerate

   logic dep_hit;
   fx_t  s1_fx, s2_fx;

   hzd2_dep_detect #(.RIDX_W(RIDX_W), .NUM_SRC(NUM_SRC)) u_dep (
      .src   (s1_src),
      .wr_en (s2_wr_en),
      .rd    (s2_rd),
      .hit   (dep_hit)
   );

   // a redirect takes priority over a dependence stall
   assign flush = redirect;
   assign stall = dep_hit & ~redirect;

   hzd2_pc_reg #(.XLEN(XLEN), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)) u_pc (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (stall),
      .load    (redirect),
      .load_pc (redirect_pc),
      .pc      (pc)
   );

   assign s1_fx = '{wr: s1_wr_en, mw: s1_mem_wr, br: s1_branch, jp: s1_jump};

   hzd2_s2_reg #(.INSN_W(INSN_W), .RIDX_W(RIDX_W), .NOP_WORD(NOP_WORD)) u_s2 (
      .clk      (clk),
      .rst_n    (rst_n),
      .kill     (stall | flush),
      .in_insn  (s1_insn),
      .in_rd    (s1_rd),
      .in_fx    (s1_fx),
      .out_insn (s2_insn),
      .out_rd   (s2_rd),
      .out_fx   (s2_fx)
   );

   assign s2_wr_en  = s2_fx.wr;
   assign s2_mem_wr = s2_fx.mw;
   assign s2_branch = s2_fx.br;
   assign s2_jump   = s2_fx.jp;

   // R2
   stall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> s2_wr_en);
   // R5
   flush_fx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!s2_wr_en && !s2_mem_wr && !s2_branch && !s2_jump));
endmodule

// File: tb/hzd2_ctrl_test.sv
module hzd2_ctrl_test;
   localparam logic [31:0] NOP = 32'h0000_000F;

   typedef struct packed {
      logic        wr;
      logic [4:0]  rd;
      logic [4:0]  ra;
      logic [4:0]  rb;
      logic        mw;
      logic        br;
      logic        jp;
      logic        tk;
      logic [31:0] tgt;
   } ent_t;

   typedef struct {
      logic [31:0] pc;
      logic [31:0] insn;
      logic        wr, mw, br, jp;
      string       pc_tag;
      string       slot_tag;
   } exp_t;

   logic        clk = 0;
   logic        rst_n = 1;
   logic [31:0] s1_insn = NOP;
   logic [9:0]  s1_src = '0;
   logic        s1_wr_en = 0, s1_mem_wr = 0, s1_branch = 0, s1_jump = 0;
   logic [4:0]  s1_rd = '0;
   logic        redirect = 0;
   logic [31:0] redirect_pc = '0;
   logic [31:0] pc, s2_insn;
   logic        stall, flush, s2_wr_en, s2_mem_wr, s2_branch, s2_jump;
   logic [4:0]  s2_rd;

   int n_chk = 0, n_bad = 0;
   int dut_stalls = 0, mdl_stalls = 0;
   exp_t q[$];
   bit   mon_on = 0;

   hzd2_ctrl uut (
      .clk(clk), .rst_n(rst_n), .s1_insn(s1_insn), .s1_src(s1_src),
      .s1_wr_en(s1_wr_en), .s1_rd(s1_rd), .s1_mem_wr(s1_mem_wr),
      .s1_branch(s1_branch), .s1_jump(s1_jump), .redirect(redirect),
      .redirect_pc(redirect_pc), .pc(pc), .stall(stall), .flush(flush),
      .s2_insn(s2_insn), .s2_wr_en(s2_wr_en), .s2_rd(s2_rd),
      .s2_mem_wr(s2_mem_wr), .s2_branch(s2_branch), .s2_jump(s2_jump)
   );

   always #4 clk = ~clk;

   function automatic ent_t mk(logic wr, int rd, int ra, int rb, logic mw,
                               logic br, logic jp, logic tk, int tgt);
      ent_t e;
      e.wr = wr; e.rd = 5'(rd); e.ra = 5'(ra); e.rb = 5'(rb);
      e.mw = mw; e.br = br; e.jp = jp; e.tk = tk; e.tgt = 32'(tgt);
      return e;
   endfunction

   // program: index = pc/4; instruction word = 32'h1000_0000 | index
   function automatic ent_t prog(int i);
      case (i)
         0:  return mk(1, 1, 2, 3, 0, 0, 0, 0, 0);    // r1 <- r2,r3
         1:  return mk(1, 4, 2, 1, 0, 0, 0, 0, 0);    // reads r1 as second source
         2:  return mk(0, 0, 4, 5, 1, 0, 0, 0, 0);    // store, reads r4
         3:  return mk(1, 6, 7, 0, 0, 0, 0, 0, 0);    // load r6
         4:  return mk(1, 8, 6, 9, 0, 0, 0, 0, 0);    // load-use on r6
         5:  return mk(0, 0, 8, 10, 0, 1, 0, 0, 0);   // branch not taken, reads r8
         6:  return mk(1, 11, 12, 13, 0, 0, 0, 0, 0); // independent
         7:  return mk(0, 0, 14, 15, 0, 1, 0, 1, 48); // taken branch to 12
         8:  return mk(1, 20, 11, 0, 0, 0, 0, 0, 0);  // wrong path
         12: return mk(1, 31, 1, 0, 0, 0, 1, 1, 64);  // linking jump to 16
         13: return mk(1, 2, 31, 3, 0, 0, 0, 0, 0);   // wrong path reading r31
         16: return mk(1, 5, 5, 6, 0, 0, 0, 0, 0);
         17: return mk(1, 7, 0, 0, 0, 0, 0, 0, 0);    // r5 written, not read
         18: return mk(1, 9, 1, 7, 0, 0, 0, 0, 0);    // reads r7 as second source
         20: return mk(0, 0, 0, 0, 0, 1, 0, 1, 0);    // taken branch to 0
         default: return mk(0, 0, 0, 0, 0, 0, 0, 0, 0);
      endcase
   endfunction

   task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   // monitor: pops expected slot/pc after each clock edge
   always @(posedge clk) begin
      #2;
      if (mon_on && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(pc == e.pc, e.pc_tag, "pc", pc, e.pc);
         check(s2_insn == e.insn, e.slot_tag, "s2_insn", s2_insn, e.insn);
         check({s2_wr_en, s2_mem_wr, s2_branch, s2_jump} == {e.wr, e.mw, e.br, e.jp},
               (e.insn == NOP) ? "R8" : "R9", "enables",
               32'({s2_wr_en, s2_mem_wr, s2_branch, s2_jump}),
               32'({e.wr, e.mw, e.br, e.jp}));
      end
   end

   // driver: one cycle of stimulus and reference model
   task automatic drive_cycle();
      ent_t e1, e2;
      int   i1, i2;
      bit   rd_, hz, st;
      exp_t x;
      @(negedge clk);
      i1 = int'(pc >> 2);
      e1 = prog(i1);
      i2 = (s2_insn == NOP) ? -1 : int'(s2_insn[15:0]);
      e2 = (i2 < 0) ? mk(0, 0, 0, 0, 0, 0, 0, 0, 0) : prog(i2);
      s1_insn   = 32'h1000_0000 | 32'(i1);
      s1_src    = {e1.rb, e1.ra};
      s1_wr_en  = e1.wr; s1_rd = e1.rd; s1_mem_wr = e1.mw;
      s1_branch = e1.br; s1_jump = e1.jp;
      rd_ = (i2 >= 0) && e2.tk;
      redirect    = rd_;
      redirect_pc = e2.tgt;
      hz = e2.wr && (e2.rd == e1.ra || e2.rd == e1.rb);
      st = hz && !rd_;
      #1;
      if (hz && rd_) begin
         check(stall == 1'b0, "R7", "stall", 32'(stall), 0);
         check(flush == 1'b1, "R7", "flush", 32'(flush), 1);
      end else begin
         check(stall == st, "R2", "stall", 32'(stall), 32'(st));
         check(flush == rd_, rd_ ? "R5" : "R6", "flush", 32'(flush), 32'(rd_));
      end
      if (stall) dut_stalls++;
      if (st) mdl_stalls++;
      x.pc = rd_ ? e2.tgt : (st ? pc : pc + 4);
      x.pc_tag = rd_ ? "R5" : (st ? "R3" : "R6");
      if (rd_ || st) begin
         x.insn = NOP; x.wr = 0; x.mw = 0; x.br = 0; x.jp = 0;
         x.slot_tag = rd_ ? "R5" : "R4";
      end else begin
         x.insn = s1_insn; x.wr = e1.wr; x.mw = e1.mw; x.br = e1.br; x.jp = e1.jp;
         x.slot_tag = "R9";
      end
      q.push_back(x);
   endtask

   initial begin : watchdog
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #1 rst_n = 0;
      #2;
      // R1: asynchronous reset state before any clock edge
      check(pc == 32'h0, "R1", "pc", pc, 0);
      check(s2_insn == NOP, "R1", "s2_insn", s2_insn, NOP);
      check({s2_wr_en, s2_mem_wr, s2_branch, s2_jump} == 4'b0, "R1", "enables",
            32'({s2_wr_en, s2_mem_wr, s2_branch, s2_jump}), 0);
      check(s2_rd == 5'd0, "R1", "s2_rd", 32'(s2_rd), 0);
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      mon_on = 1;
      for (int c = 0; c < 60; c++) drive_cycle();
      @(posedge clk); #3;
      // R4: one bubble per stall cycle, counted over the whole run
      check(dut_stalls == mdl_stalls, "R4", "stall count", 32'(dut_stalls), 32'(mdl_stalls));
      check(mdl_stalls >= 5, "R4", "stall coverage", 32'(mdl_stalls), 5);
      mon_on = 0;
      // R1: reset asserted between clock edges acts at once
      @(negedge clk); #1;
      rst_n = 0;
      #1;
      check(pc == 32'h0, "R1", "async pc", pc, 0);
      check(s2_insn == NOP, "R1", "async s2_insn", s2_insn, NOP);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule